// File: doc/BRIEF.md
# Runtime-Length Bit-Field Manipulation Unit

This unit edits or pulls out one contiguous field of a 64-bit word. The caller gives a source word, an offset operand and a field length. The unit builds a run of ones of that length, then moves the run to the offset. It can OR the run into the source (set), remove it (clear), XOR it (toggle), or shift the source down and keep only the field (extract). A fifth mode bit-reverses the source before it extracts, and it counts the offset from the other end of the word.

Because the length is an operand and not a constant, the unit can build a predicate mask of dynamic size in one operation: set with a zero source and zero offset. In the reversed-extract mode, a flag says that the offset comes from register index zero. The offset is then ignored, so the mode can reverse a whole word. The result is computed combinationally. Under the `OUT_REG` parameter (default 1) it then passes through one output register.

Top module: `bfm_unit`

## Requirements
- R1: The field mask has its low n bits set for a length n from 0 to 63, and all 64 bits set for any length of 64 or more (the length port is 7 bits, 0 to 127).
- R2: Operation code 0 (set) returns source OR (mask shifted left by the offset amount).
- R3: Operation code 1 (clear) returns source AND NOT (mask shifted left by the offset amount).
- R4: Operation code 2 (toggle) returns source XOR (mask shifted left by the offset amount).
- R5: Operation code 3 (extract) returns mask AND (source logically shifted right by the offset amount), with zeros filling in from the top and no rotation.
- R6: The offset amount is bit 5 down to bit 0 of the offset operand. Bits 63 to 6 have no effect on any operation.
- R7: Operation code 4 (reversed extract) with the zero-index flag low bit-reverses the source (bit i moves to bit 63−i), shifts it right by 63 minus the offset amount, and ANDs the result with the mask.
- R8: In operation code 4 with the zero-index flag high, no shift is applied. With a length of 64 the result is the full bit reversal of the source.
- R9: The zero-index flag has no effect on operation codes 0 to 3.
- R10: Operation codes 5, 6 and 7 return the source unchanged.
- R11: Set with a zero source, a zero offset and length n gives exactly n ones starting at bit 0.
- R12: With `OUT_REG`=1, the result appears on the clock edge after the inputs are applied, and synchronous reset forces the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 3 | Operation code: 0 set, 1 clear, 2 toggle, 3 extract, 4 reversed extract |
| src_i | input | 64 | Source word |
| ofs_i | input | 64 | Offset operand; only bits 5:0 are used |
| len_i | input | 7 | Field length; 64 or more means the whole word |
| zidx_i | input | 1 | Offset register index is zero (used only by reversed extract) |
| res_o | output | 64 | Result |

## Verification
Two pieces of logic can act on the same operation: the length saturation, and the offset wrap or reversal. A length of 64 or more combined with an offset operand whose high bits are set tests both in one operation. Reversed extract with the zero-index flag high overrides the offset calculation while the reversal network is active. The bench drives these overlaps as directed corners, sweeping lengths and offsets at 0, 1, 63, 64 and above. It also applies seeded random operations. Each result is compared, one clock after it is applied, with a model the bench computes from the formulas in the requirements.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

    localparam int WORD_W = 64;

    typedef enum logic [2:0] {
        BF_SET  = 3'd0,
        BF_CLR  = 3'd1,
        BF_TOG  = 3'd2,
        BF_EXT  = 3'd3,
        BF_REXT = 3'd4
    } bf_op_e;

    function automatic bit op_is_known(input logic [2:0] code);
        return code <= 3'd4;
    endfunction

endpackage

// File: rtl/bfm_mask_gen.sv
module bfm_mask_gen #(
    parameter int W    = bfm_pkg::WORD_W,
    parameter int LENW = $clog2(W) + 1
) (
    input  logic [LENW-1:0] len_i,
    output logic [W-1:0]    mask_o
);
    // Thermometer code: bit i is set when the length exceeds i.
    // A length of W or more therefore saturates to all ones.
    for (genvar i = 0; i < W; i++) begin : g_therm
        assign mask_o[i] = (len_i > LENW'(i));
    end
endmodule

// File: rtl/bfm_shamt.sv
module bfm_shamt #(
    parameter int W   = bfm_pkg::WORD_W,
    parameter int SHW = $clog2(W)
) (
    input  logic [2:0]     op_i,
    input  logic [W-1:0]   ofs_i,
    input  logic           zidx_i,
    output logic [SHW-1:0] shamt_o
);
    import bfm_pkg::*;

    logic [SHW-1:0] raw;
    logic           unused_ofs_hi;

    assign raw           = ofs_i[SHW-1:0];
    assign unused_ofs_hi = ^ofs_i[W-1:SHW];

    always_comb begin
        if (bf_op_e'(op_i) == BF_REXT) begin
            // reversed extract counts the offset from the far end
            shamt_o = zidx_i ? '0 : (SHW'(W - 1) - raw);
        end else begin
            shamt_o = raw;
        end
    end
endmodule

// File: rtl/bfm_datapath.sv
module bfm_datapath #(
    parameter int W   = bfm_pkg::WORD_W,
    parameter int SHW = $clog2(W)
) (
    input  logic [2:0]     op_i,
    input  logic [W-1:0]   src_i,
    input  logic [W-1:0]   mask_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   res_o
);
    import bfm_pkg::*;

    logic [W-1:0] src_rev;
    logic [W-1:0] placed;
    logic [W-1:0] down_in;
    logic [W-1:0] down;

    for (genvar i = 0; i < W; i++) begin : g_rev
        assign src_rev[i] = src_i[W-1-i];
    end

    always_comb begin
        placed  = mask_i << shamt_i;
        down_in = (bf_op_e'(op_i) == BF_REXT) ? src_rev : src_i;
        down    = down_in >> shamt_i;
        if (!op_is_known(op_i)) begin
            res_o = src_i;
        end else begin
            case (bf_op_e'(op_i))
                BF_SET:  res_o = src_i | placed;
                BF_CLR:  res_o = src_i & ~placed;
                BF_TOG:  res_o = src_i ^ placed;
                default: res_o = mask_i & down;
            endcase
        end
    end
endmodule

// File: rtl/bfm_unit.sv
module bfm_unit #(
    parameter int W       = bfm_pkg::WORD_W,
    parameter bit OUT_REG = 1'b1,
    parameter int SHW     = $clog2(W),
    parameter int LENW    = SHW + 1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [2:0]      op_i,
    input  logic [W-1:0]    src_i,
    input  logic [W-1:0]    ofs_i,
    input  logic [LENW-1:0] len_i,
    input  logic            zidx_i,
    output logic [W-1:0]    res_o
);
    import bfm_pkg::*;

    logic [W-1:0]   mask_w;
    logic [SHW-1:0] shamt_w;
    logic [W-1:0]   core_res;
    logic           rst_d;

    bfm_mask_gen #(.W(W), .LENW(LENW)) u_mask (
        .len_i  (len_i),
        .mask_o (mask_w)
    );

    bfm_shamt #(.W(W), .SHW(SHW)) u_shamt (
        .op_i    (op_i),
        .ofs_i   (ofs_i),
        .zidx_i  (zidx_i),
        .shamt_o (shamt_w)
    );

    bfm_datapath #(.W(W), .SHW(SHW)) u_dp (
        .op_i    (op_i),
        .src_i   (src_i),
        .mask_i  (mask_w),
        .shamt_i (shamt_w),
        .res_o   (core_res)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) res_o <= '0;
            else     res_o <= core_res;
        end
    end else begin : g_comb
        assign res_o = core_res;
    end

    always_ff @(posedge clk) rst_d <= rst;

    // R1: mask population equals the saturated length
    a_r1_mask_count: assert property (@(posedge clk) disable iff (rst)
        $countones(mask_w) == ((int'(len_i) >= W) ? W : int'(len_i)));

    // R2: set never drops a source bit
    a_r2_set_superset: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd0) |-> ((core_res & src_i) == src_i));

    // R3: clear never raises a bit
    a_r3_clr_subset: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd1) |-> ((core_res & ~src_i) == '0));

    // R4: toggle changes at most as many bits as the mask holds
    a_r4_tog_bounded: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd2) |-> ($countones(core_res ^ src_i) <= $countones(mask_w)));

    // R5: extract result lies inside the mask
    a_r5_ext_in_mask: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd3 || op_i == 3'd4) |-> ((core_res & ~mask_w) == '0));

    // R8: reversed extract, zero index, full length gives a reversal
    a_r8_full_reverse: assert property (@(posedge clk) disable iff (rst)
        (op_i == 3'd4 && zidx_i && int'(len_i) >= W)
            |-> (core_res[W-1] == src_i[0] && core_res[0] == src_i[W-1]));

    // R10: unknown codes pass the source through
    a_r10_passthru: assert property (@(posedge clk) disable iff (rst)
        (op_i > 3'd4) |-> (core_res == src_i));

    // R12: registered output follows the combinational result by one edge
    a_r12_latency: assert property (@(posedge clk) disable iff (rst || rst_d)
        OUT_REG |=> (res_o == $past(core_res)));

endmodule

// File: tb/bfm_unit_tb.sv
module bfm_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_i = '0;
    logic [63:0] src_i = '0;
    logic [63:0] ofs_i = '0;
    logic [6:0]  len_i = '0;
    logic        zidx_i = 1'b0;
    logic [63:0] res_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bfm_unit u_dut (
        .clk (clk), .rst (rst), .op_i (op_i), .src_i (src_i),
        .ofs_i (ofs_i), .len_i (len_i), .zidx_i (zidx_i), .res_o (res_o)
    );

    function automatic logic [63:0] rev64(input logic [63:0] v);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = v[63-i];
        return r;
    endfunction

    function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] s,
                                         input logic [63:0] o, input logic [6:0] n,
                                         input logic z);
        logic [63:0] m;
        int sh;
        m  = (n >= 7'd64) ? '1 : ((64'd1 << n) - 64'd1);
        sh = int'(o[5:0]);
        case (op)
            3'd0: return s | (m << sh);
            3'd1: return s & ~(m << sh);
            3'd2: return s ^ (m << sh);
            3'd3: return m & (s >> sh);
            3'd4: return m & (rev64(s) >> (z ? 0 : 63 - sh));
            default: return s;
        endcase
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [2:0] op, input logic [63:0] s,
                         input logic [63:0] o, input logic [6:0] n, input logic z,
                         input logic [63:0] exp);
        @(negedge clk);
        op_i = op; src_i = s; ofs_i = o; len_i = n; zidx_i = z;
        @(posedge clk);
        @(negedge clk);
        check(tag, res_o, exp);
    endtask

    task automatic run(input string tag, input logic [2:0] op, input logic [63:0] s,
                       input logic [63:0] o, input logic [6:0] n, input logic z);
        apply(tag, op, s, o, n, z, model(op, s, o, n, z));
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    initial begin
        logic [63:0] pat;
        pat = 64'hC3A5_0F1E_9B27_D468;
        src_i = pat; op_i = 3'd2; len_i = 7'd64;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R12 reset clears result", res_o, 64'd0);
        rst = 1'b0;

        // R12: one-edge latency after reset release
        apply("R12 latency", 3'd2, pat, 64'd0, 7'd64, 1'b0, ~pat);

        // R1/R11: run of ones from a zero source
        for (int n = 0; n <= 70; n++) begin
            apply("R11 run of ones", 3'd0, 64'd0, 64'd0, 7'(n), 1'b0,
                  (n >= 64) ? '1 : ((64'd1 << n) - 64'd1));
        end
        apply("R1 length 127 saturates", 3'd3, '1, 64'd0, 7'd127, 1'b0, '1);

        // directed corners for every op
        foreach (pat[k]) begin end
        for (int op = 0; op < 5; op++) begin
            for (int li = 0; li < 5; li++) begin
                for (int oi = 0; oi < 5; oi++) begin
                    logic [6:0]  n;
                    logic [63:0] o;
                    n = (li == 0) ? 7'd0 : (li == 1) ? 7'd1 : (li == 2) ? 7'd63 :
                        (li == 3) ? 7'd64 : 7'd100;
                    o = (oi == 0) ? 64'd0 : (oi == 1) ? 64'd1 : (oi == 2) ? 64'd63 :
                        (oi == 3) ? 64'd64 : 64'hFFFF_0000_0000_0045;
                    case (op)
                        0: run("R2 set corner", 3'd0, pat, o, n, 1'b0);
                        1: run("R3 clear corner", 3'd1, pat, o, n, 1'b0);
                        2: run("R4 toggle corner", 3'd2, pat, o, n, 1'b0);
                        3: run("R5 extract corner", 3'd3, pat, o, n, 1'b0);
                        default: run("R7 rev extract corner", 3'd4, pat, o, n, 1'b0);
                    endcase
                end
            end
        end

        // R5: right shift, not rotate
        apply("R5 no rotate", 3'd3, 64'h0000_0000_0000_00FF, 64'd4, 7'd64, 1'b0,
              64'h0000_0000_0000_000F);
        // R6: high offset bits ignored
        apply("R6 offset wrap", 3'd0, 64'd0, 64'hABCD_0000_0000_0045, 7'd3, 1'b0,
              64'd7 << 5);
        // R7: offset 63 gives reversed source under mask
        apply("R7 rev offset 63", 3'd4, 64'h1, 64'd63, 7'd64, 1'b0, 64'h8000_0000_0000_0000);
        // R8: zero index gives full reversal regardless of offset
        apply("R8 full reverse", 3'd4, pat, 64'd17, 7'd64, 1'b1, rev64(pat));
        apply("R8 reverse low byte", 3'd4, 64'h8000_0000_0000_0000, 64'd5, 7'd8, 1'b1, 64'h1);
        // R9: flag has no effect outside reversed extract
        for (int op = 0; op < 4; op++) begin
            apply("R9 flag ignored", 3'(op), pat, 64'd9, 7'd12, 1'b1,
                  model(3'(op), pat, 64'd9, 7'd12, 1'b0));
        end
        // R10: unknown codes
        for (int op = 5; op < 8; op++) begin
            apply("R10 passthrough", 3'(op), pat, 64'd3, 7'd64, 1'b1, pat);
        end

        // seeded random mix
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 400; i++) begin
            logic [2:0]  op;
            logic [63:0] s;
            logic [63:0] o;
            logic [6:0]  n;
            logic        z;
            op = 3'($urandom % 8);
            s  = {$urandom, $urandom};
            o  = {$urandom, $urandom};
            n  = 7'($urandom % 80);
            z  = 1'($urandom % 2);
            case (op)
                3'd0: run("R2 random", op, s, o, n, z);
                3'd1: run("R3 random", op, s, o, n, z);
                3'd2: run("R4 random", op, s, o, n, z);
                3'd3: run("R5 random", op, s, o, n, z);
                3'd4: run("R7 random", op, s, o, n, z);
                default: run("R10 random", op, s, o, n, z);
            endcase
        end

        finish_run();
    end

endmodule